// File: doc/BRIEF.md
# Coded-Ratio Clock Enable Bank

This block is a set of divider channels that all run from one fast reference clock. Each channel emits a single-cycle enable strobe once every N reference cycles. N is picked by a 4-bit code from a fixed table of sixteen entries. The table holds ratios that are not powers of two, and two of its entries are unused. Downstream logic uses the strobes as clock enables, so the block creates no derived clocks.

Software sets the block up through a two-word register write port. Ratio codes written there are only staged. They reach the counters after a kick bit is written. Each channel then changes over at the end of its current period, so no interval is ever cut short. The kick stays visible as a busy flag until every channel has taken its new code.

Each channel has its own mask of permitted codes. A rejected field keeps its old staged value and sets a sticky error flag. Channels can also be switched off, and part of the bank is off after reset.

Top module: `ratio_strobe_bank`

## Requirements
- R1: After reset every channel's applied code is 0, `kick_busy` and `cfg_err` are 0, channels 0 to 3 are enabled, and channels 4 and 5 are disabled.
- R2: An enabled channel pulses `tick` for exactly one cycle in every N reference cycles, and never in two consecutive cycles. N is looked up from the applied code: 0:2, 1:3, 2:4, 3:6, 4:8, 5:12, 6:16, 7:18, 8:24, 9:32, 10:36, 11:48, 13:72, 14:96.
- R3: Word 0 (`wr_addr`=0) holds the codes of channels 0, 1, 2, 3 and 4 at bits 23:20, 19:16, 11:8, 7:4 and 3:0. Word 1 holds the code of channel 5 at bits 3:0, the channel enables at bits 13:8 (bit 8+i is channel i), the error-clear at bit 30 and the kick at bit 31. Every write to a word writes all of that word's fields.
- R4: A code write alone changes neither `act_code` nor the strobe period.
- R5: Channels 0 to 4 accept codes in mask 0x6fff and channel 5 accepts codes in mask 0x677c, where bit n set permits code n. A field holding a code outside its channel's mask keeps its staged value, and the other fields of the same write are still taken.
- R6: A rejected field sets `cfg_err`, which stays set until a write of 1 to word 1 bit 30. A rejection in that same write keeps `cfg_err` set.
- R7: A kick raises `kick_busy` in the cycle after the write. Each channel loads its staged code when its current period ends. `kick_busy` falls once all channels have loaded their codes.
- R8: The interval that spans a ratio change equals the old divisor, and the intervals after it equal the new divisor.
- R9: A disabled channel emits no ticks and loads a kicked code at once. After it is enabled again, its first tick comes N-1 cycles after the enabling write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Word select: 0 holds channel codes 0 to 4, 1 holds channel 5, enables, error-clear and kick |
| wr_data | input | 32 | Write data |
| tick | output | 6 | One enable strobe per channel |
| act_code | output | 24 | Applied code per channel, channel i at bits 4i+3:4i |
| kick_busy | output | 1 | A kick is pending on at least one channel |
| cfg_err | output | 1 | Sticky flag for a rejected code |

## Verification
The hardest case to reach is a kick that arrives partway through a long period. It must be shown that the changeover waits for the period boundary rather than cutting the period short. The bench first syncs to a strobe of a channel running at divide-by-12. It then issues the kick a known number of cycles later and times the spanning interval, followed by the first interval at the new ratio. Rejection is shown only through the ports: a later kick must bring the earlier legal code into `act_code`.

// File: rtl/ratio_strobe_pkg.sv
package ratio_strobe_pkg;

    localparam int CH_COUNT   = 6;
    localparam int CODE_W     = 4;
    localparam int DIV_W      = 7;
    localparam int DATA_W     = 32;
    localparam int EN_LSB     = 8;
    localparam int ERRCLR_BIT = 30;
    localparam int KICK_BIT   = 31;

    // Field position and owning word per channel
    localparam int   FIELD_OFS  [CH_COUNT] = '{20, 16, 8, 4, 0, 0};
    localparam logic FIELD_WORD [CH_COUNT] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [15:0] CODE_MASK [CH_COUNT] =
        '{16'h6fff, 16'h6fff, 16'h6fff, 16'h6fff, 16'h6fff, 16'h677c};
    localparam logic [CH_COUNT-1:0] EN_RESET = 6'b001111;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DIV_W-1:0]  div_t;

    function automatic div_t code_to_div(code_t c);
        case (c)
            4'd0:    return div_t'(2);
            4'd1:    return div_t'(3);
            4'd2:    return div_t'(4);
            4'd3:    return div_t'(6);
            4'd4:    return div_t'(8);
            4'd5:    return div_t'(12);
            4'd6:    return div_t'(16);
            4'd7:    return div_t'(18);
            4'd8:    return div_t'(24);
            4'd9:    return div_t'(32);
            4'd10:   return div_t'(36);
            4'd11:   return div_t'(48);
            4'd13:   return div_t'(72);
            4'd14:   return div_t'(96);
            default: return div_t'(2);
        endcase
    endfunction

endpackage

// File: rtl/ratio_stage_regs.sv
module ratio_stage_regs
    import ratio_strobe_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [NUM_CH-1:0]        loaded,
    output code_t [NUM_CH-1:0]       staged,
    output logic [NUM_CH-1:0]        ch_en,
    output logic [NUM_CH-1:0]        pend,
    output logic                     err
);

    code_t [NUM_CH-1:0] field_val;
    logic  [NUM_CH-1:0] field_wr;
    logic  [NUM_CH-1:0] field_ok;
    logic  [NUM_CH-1:0] reject;
    logic               word1_wr;
    logic               kick_wr;
    logic               clr_wr;
    logic               unused_ok;

    assign word1_wr  = wr_en && wr_addr;
    assign kick_wr   = word1_wr && wr_data[KICK_BIT];
    assign clr_wr    = word1_wr && wr_data[ERRCLR_BIT];
    assign unused_ok = ^wr_data;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_field
        assign field_val[g] = wr_data[FIELD_OFS[g] +: CODE_W];
        assign field_wr[g]  = wr_en && (wr_addr == FIELD_WORD[g]);
        assign field_ok[g]  = CODE_MASK[g][field_val[g]];
        assign reject[g]    = field_wr[g] && !field_ok[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                staged[g] <= '0;
            end else if (field_wr[g] && field_ok[g]) begin
                staged[g] <= field_val[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_en <= EN_RESET[NUM_CH-1:0];
            pend  <= '0;
            err   <= 1'b0;
        end else begin
            if (word1_wr) begin
                ch_en <= wr_data[EN_LSB +: NUM_CH];
            end
            if (kick_wr) begin
                pend <= '1;
            end else begin
                pend <= pend & ~loaded;
            end
            if (|reject) begin
                err <= 1'b1;
            end else if (clr_wr) begin
                err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ratio_chan.sv
module ratio_chan
    import ratio_strobe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  pend,
    input  code_t next_code,
    output logic  tick,
    output logic  loaded,
    output code_t cur_code
);

    div_t cnt;
    div_t cur_div;
    logic at_end;

    assign cur_div = code_to_div(cur_code);
    assign at_end  = (cnt == cur_div - div_t'(1));
    assign tick    = enable && at_end;
    assign loaded  = pend && (!enable || at_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            cur_code <= '0;
        end else begin
            if (!enable || at_end) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + div_t'(1);
            end
            if (loaded) begin
                cur_code <= next_code;
            end
        end
    end

endmodule

// File: rtl/ratio_strobe_bank.sv
module ratio_strobe_bank
    import ratio_strobe_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH-1:0]        tick,
    output logic [NUM_CH*CODE_W-1:0] act_code,
    output logic                     kick_busy,
    output logic                     cfg_err
);

    code_t [NUM_CH-1:0] staged;
    logic  [NUM_CH-1:0] ch_en;
    logic  [NUM_CH-1:0] pend;
    logic  [NUM_CH-1:0] loaded;

    ratio_stage_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .loaded  (loaded),
        .staged  (staged),
        .ch_en   (ch_en),
        .pend    (pend),
        .err     (cfg_err)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        code_t code_q;
        ratio_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .enable    (ch_en[g]),
            .pend      (pend[g]),
            .next_code (staged[g]),
            .tick      (tick[g]),
            .loaded    (loaded[g]),
            .cur_code  (code_q)
        );
        assign act_code[g*CODE_W +: CODE_W] = code_q;
    end

    assign kick_busy = |pend;

endmodule

// File: rtl/ratio_strobe_bank_chk.sv
module ratio_strobe_bank_chk
    import ratio_strobe_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic                     wr_addr,
    input logic [DATA_W-1:0]        wr_data,
    input logic [NUM_CH-1:0]        tick,
    input logic [NUM_CH*CODE_W-1:0] act_code,
    input logic                     kick_busy,
    input logic                     cfg_err,
    input logic [NUM_CH-1:0]        ch_en
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R9: no strobe from a disabled channel
        assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
            !ch_en[i] |-> !tick[i]);
        // R2: strobes never back to back
        assert_no_double_R2: assert property (@(posedge clk) disable iff (rst)
            tick[i] |=> !tick[i]);
        // R8: applied code changes only after a period end or while disabled
        assert_switch_boundary_R8: assert property (@(posedge clk) disable iff (rst)
            !$stable(act_code[i*CODE_W +: CODE_W]) |-> $past(tick[i] || !ch_en[i]));
        // R5: a newly applied code is one the channel permits
        assert_legal_applied_R5: assert property (@(posedge clk) disable iff (rst)
            !$stable(act_code[i*CODE_W +: CODE_W]) |->
                CODE_MASK[i][act_code[i*CODE_W +: CODE_W]]);
    end

    // R6: error flag holds unless cleared
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_err && !(wr_en && wr_addr && wr_data[ERRCLR_BIT]) |=> cfg_err);
    // R7: a kick write shows busy next cycle
    assert_kick_busy_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr && wr_data[KICK_BIT] |=> kick_busy);
    // R4: applied codes only move while a kick is pending
    assert_hold_without_kick_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_code) |-> $past(kick_busy));

endmodule

bind ratio_strobe_bank ratio_strobe_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tick      (tick),
    .act_code  (act_code),
    .kick_busy (kick_busy),
    .cfg_err   (cfg_err),
    .ch_en     (ch_en)
);

// File: tb/ratio_strobe_bank_test.sv
module ratio_strobe_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [5:0]  tick;
    logic [23:0] act_code;
    logic        kick_busy;
    logic        cfg_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ratio_strobe_bank uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tick      (tick),
        .act_code  (act_code),
        .kick_busy (kick_busy),
        .cfg_err   (cfg_err)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] w0(int c0, int c1, int c2, int c3, int c4);
        return (32'(c0) << 20) | (32'(c1) << 16) | (32'(c2) << 8) | (32'(c3) << 4) | 32'(c4);
    endfunction

    function automatic logic [31:0] w1(int c5, int en, bit clr, bit kick);
        return (32'(kick) << 31) | (32'(clr) << 30) | (32'(en) << 8) | 32'(c5);
    endfunction

    function automatic int code_of(int ch);
        return int'(act_code[ch*4 +: 4]);
    endfunction

    task automatic reg_write(logic a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 400 && kick_busy; n++) @(negedge clk);
    endtask

    task automatic gap(int ch, output int g);
        for (int n = 0; n < 400 && !tick[ch]; n++) @(negedge clk);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!tick[ch] && g < 400);
    endtask

    task automatic quiet(int ch, int cycles, output bit seen);
        seen = 0;
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            if (tick[ch]) seen = 1;
        end
    endtask

    task automatic t_reset();
        int g;
        bit s;
        check(act_code == 24'h0, "R1 codes", int'(act_code), 0);
        check(!kick_busy && !cfg_err, "R1 flags", int'({kick_busy, cfg_err}), 0);
        quiet(5, 20, s);
        check(!s, "R1 ch5 off", int'(s), 0);
        gap(0, g);
        check(g == 2, "R2 reset period", g, 2);
    endtask

    task automatic t_staging();
        int g;
        reg_write(1'b0, w0(5, 14, 13, 1, 7));
        check(act_code == 24'h0 && !kick_busy, "R4 no apply", int'(act_code), 0);
        gap(0, g);
        check(g == 2, "R4 period held", g, 2);
    endtask

    task automatic t_kick();
        int g;
        bit s;
        reg_write(1'b1, w1(2, 6'b001111, 0, 1));
        check(kick_busy == 1'b1, "R7 busy rises", int'(kick_busy), 1);
        wait_idle();
        check(!kick_busy, "R7 busy falls", int'(kick_busy), 0);
        check(code_of(0) == 5 && code_of(1) == 14 && code_of(2) == 13, "R3 word0 fields",
              int'(act_code), 24'h2_7_1_d_e_5);
        check(code_of(3) == 1 && code_of(4) == 7 && code_of(5) == 2, "R3 fields low",
              int'(act_code), 24'h2_7_1_d_e_5);
        gap(0, g); check(g == 12, "R2 div12", g, 12);
        gap(1, g); check(g == 96, "R2 div96", g, 96);
        gap(2, g); check(g == 72, "R2 div72", g, 72);
        gap(3, g); check(g == 3, "R2 div3", g, 3);
        quiet(4, 30, s);
        check(!s, "R9 disabled quiet", int'(s), 0);
    endtask

    task automatic t_reject();
        int g;
        reg_write(1'b0, w0(12, 15, 0, 6, 3));
        check(cfg_err == 1'b1, "R6 err set", int'(cfg_err), 1);
        reg_write(1'b1, w1(7, 6'b001111, 1, 0));
        check(cfg_err == 1'b1, "R6 reject beats clear", int'(cfg_err), 1);
        reg_write(1'b1, w1(0, 6'b001111, 0, 0));
        check(cfg_err == 1'b1, "R5 ch5 code0 rejected", int'(cfg_err), 1);
        reg_write(1'b1, w1(4, 6'b111111, 1, 0));
        check(cfg_err == 1'b0, "R6 err cleared", int'(cfg_err), 0);
        reg_write(1'b1, w1(4, 6'b111111, 0, 1));
        wait_idle();
        check(code_of(0) == 5 && code_of(1) == 14, "R5 illegal kept", int'(act_code[7:0]), 8'he5);
        check(code_of(2) == 0 && code_of(3) == 6 && code_of(4) == 3 && code_of(5) == 4,
              "R5 legal taken", int'(act_code[23:8]), 16'h4360);
        gap(3, g); check(g == 16, "R2 div16", g, 16);
        gap(4, g); check(g == 6, "R2 div6", g, 6);
        gap(5, g); check(g == 8, "R2 div8", g, 8);
    endtask

    task automatic t_boundary();
        int g;
        int n;
        reg_write(1'b0, w0(0, 14, 0, 6, 3));
        for (int k = 0; k < 400 && !tick[0]; k++) @(negedge clk);
        n = 0;
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = w1(4, 6'b111111, 0, 1);
        @(negedge clk);
        n++;
        wr_en = 1'b0; wr_data = '0;
        while (!tick[0] && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(n == 12, "R8 spanning interval", n, 12);
        gap(0, g);
        check(g == 2, "R8 new interval", g, 2);
        wait_idle();
    endtask

    task automatic t_disable();
        bit s;
        int n;
        reg_write(1'b1, w1(4, 6'b110111, 0, 0));
        quiet(3, 40, s);
        check(!s, "R9 off quiet", int'(s), 0);
        reg_write(1'b1, w1(4, 6'b111111, 0, 0));
        n = 0;
        while (!tick[3] && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(n == 15, "R9 restart delay", n, 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_staging();
        t_kick();
        t_reject();
        t_boundary();
        t_disable();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule